// File: doc/BRIEF.md
# Header Tank Pump Controller

This block runs the pump that refills a small header tank from a large reservoir, and it drives a warning lamp. Three level sensors feed it: header tank full, header tank empty, and reservoir low. All three are active high, so a 1 means the named condition is true. Each sensor passes through a synchroniser. A two-state machine, idle and pumping, then decides whether the pump runs. Both outputs are active high and registered.

The pump starts only when the header tank reports empty and the reservoir is not low. It then stays on until the full sensor trips. The gap between the two level sensors gives the pump hysteresis. A low reservoir stops the pump at once and lights the lamp for as long as the condition lasts. If the full and empty sensors both read 1, the header is treated as full, so a faulty sensor pair cannot start the pump.

Top module: `tank_pump_ctrl`

## Requirements
- R1: When `rst` is high at a rising clock edge, the machine goes to idle and both `pump_o` and `lamp_o` read 0 after that edge. The synchronisers are cleared too, so inputs applied while reset is high take effect only after reset is released.
- R2: `lamp_o` follows `res_low_i`, changing on the third rising edge after the input changes (two synchroniser stages plus the output register).
- R3: From idle, with `hdr_empty_i`=1, `hdr_full_i`=0 and `res_low_i`=0, `pump_o` rises on the third rising edge after the inputs are applied, and not earlier.
- R4: While pumping, `pump_o` stays 1 when `hdr_empty_i` returns to 0, as long as `hdr_full_i` and `res_low_i` stay 0.
- R5: While pumping, `pump_o` falls on the third rising edge after `hdr_full_i` rises, and the machine returns to idle.
- R6: `res_low_i`=1 forces `pump_o` to 0, with the same three-edge latency, and blocks any start for as long as it holds. `lamp_o` and `pump_o` are never both 1.
- R7: With `hdr_full_i` and `hdr_empty_i` both 1 (sensor fault), the pump does not start from idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hdr_full_i | input | 1 | Header tank full sensor, 1 = full |
| hdr_empty_i | input | 1 | Header tank empty sensor, 1 = empty |
| res_low_i | input | 1 | Reservoir low sensor, 1 = only reserve left |
| pump_o | output | 1 | Pump enable, 1 = run |
| lamp_o | output | 1 | Warning lamp enable, 1 = on |

## Verification
The only internal state is the pump/idle bit, and `pump_o` shows it directly. A wrong state therefore appears at the port on the edge where it occurs. Because the inputs pass through three registers, the bench checks each output both one edge before it is due to change and on the edge where it changes, so an error in latency shows up as well as an error in value. The hysteresis case is the key one: removing the empty request while pumping must leave `pump_o` at 1. If the machine had fallen back to idle, this would show within three edges of the request being removed.

// File: rtl/tank_pump_pkg.sv
package tank_pump_pkg;
  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_FILL = 1'b1
  } pump_state_t;

  localparam int SENSOR_CNT = 3;
  localparam int IDX_FULL   = 0;
  localparam int IDX_EMPTY  = 1;
  localparam int IDX_LOW    = 2;
endpackage

// File: rtl/level_sync.sv
module level_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[LAST];
  end
endmodule

// File: rtl/pump_fsm.sv
module pump_fsm
  import tank_pump_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic full_s,
  input  logic empty_s,
  input  logic low_s,
  output logic pump_q,
  output logic lamp_q
);
  pump_state_t state_q, state_d;
  logic        start_ok, stop_req;

  // A fault with both level sensors set counts as full.
  assign start_ok = empty_s && !full_s && !low_s;
  assign stop_req = full_s || low_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE: if (start_ok) state_d = PS_FILL;
      PS_FILL: if (stop_req) state_d = PS_IDLE;
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      pump_q  <= 1'b0;
      lamp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pump_q  <= (state_d == PS_FILL);
      lamp_q  <= low_s;
    end
  end

  AST_START_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (!pump_q && empty_s && !full_s && !low_s) |=> pump_q); // R3
  AST_HOLD_HYST: assert property (@(posedge clk) disable iff (rst)
    (pump_q && !full_s && !low_s) |=> pump_q); // R4
  AST_STOP_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    (pump_q && full_s) |=> !pump_q); // R5
  AST_LOW_INTERLOCK: assert property (@(posedge clk) disable iff (rst)
    low_s |=> !pump_q); // R6
  AST_FAULT_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!pump_q && full_s) |=> !pump_q); // R7
endmodule

// File: rtl/tank_pump_ctrl.sv
module tank_pump_ctrl
  import tank_pump_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hdr_full_i,
  input  logic hdr_empty_i,
  input  logic res_low_i,
  output logic pump_o,
  output logic lamp_o
);
  logic [SENSOR_CNT-1:0] raw, synced;

  assign raw[IDX_FULL]  = hdr_full_i;
  assign raw[IDX_EMPTY] = hdr_empty_i;
  assign raw[IDX_LOW]   = res_low_i;

  level_sync #(.WIDTH(SENSOR_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw),
    .sync_o  (synced)
  );

  pump_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .full_s  (synced[IDX_FULL]),
    .empty_s (synced[IDX_EMPTY]),
    .low_s   (synced[IDX_LOW]),
    .pump_q  (pump_o),
    .lamp_q  (lamp_o)
  );

  AST_LAMP_PUMP_EXCL: assert property (@(posedge clk) disable iff (rst)
    lamp_o |-> !pump_o); // R6
  AST_LAMP_TRACKS_LOW: assert property (@(posedge clk) disable iff (rst)
    synced[IDX_LOW] |=> lamp_o); // R2
endmodule

// File: tb/tb_tank_pump_ctrl.sv
module tb_tank_pump_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic full = 1'b0, empty = 1'b0, low = 1'b0;
  logic pump, lamp;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  p;
    logic  l;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  tank_pump_ctrl dut (
    .clk(clk), .rst(rst), .hdr_full_i(full), .hdr_empty_i(empty),
    .res_low_i(low), .pump_o(pump), .lamp_o(lamp)
  );

  // Monitor: compare one expected item per falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if (pump !== e.p || lamp !== e.l) begin
        n_fail++;
        $display("FAIL %s: pump/lamp actual %b/%b expected %b/%b",
                 e.tag, pump, lamp, e.p, e.l);
      end
    end
  end

  function automatic void push(logic p, logic l, string tag);
    exp_t e;
    e.p = p; e.l = l; e.tag = tag;
    sb.push_back(e);
  endfunction

  // Driver: apply the sensor levels, expect the old outputs after two
  // edges and the new outputs after the third, then check that they hold.
  task automatic step(logic f, logic e, logic l,
                      logic pp, logic pl, logic np, logic nl, string tag);
    @(negedge clk);
    full = f; empty = e; low = l;
    repeat (2) @(posedge clk);
    push(pp, pl, {tag, " before latency"});
    @(posedge clk);
    push(np, nl, tag);
    repeat (2) @(posedge clk);
    push(np, nl, {tag, " steady"});
    @(posedge clk);
  endtask

  initial begin
    // R1: reset with a start request pending keeps both outputs off
    full = 1'b0; empty = 1'b1; low = 1'b0;
    repeat (4) @(posedge clk);
    push(1'b0, 1'b0, "R1 reset state");
    @(posedge clk);
    @(negedge clk);
    empty = 1'b0;
    rst = 1'b0;
    repeat (4) @(posedge clk);

    step(0, 1, 0, 0, 0, 1, 0, "R3 start on empty");
    step(0, 0, 0, 1, 0, 1, 0, "R4 hysteresis hold");
    step(1, 0, 0, 1, 0, 0, 0, "R5 stop on full");
    step(0, 0, 0, 0, 0, 0, 0, "R4 idle stays idle");
    step(0, 0, 1, 0, 0, 0, 1, "R2 lamp on");
    step(0, 1, 1, 0, 1, 0, 1, "R6 low blocks start");
    step(0, 1, 0, 0, 1, 1, 0, "R2 lamp off and R3 start");
    step(0, 1, 1, 1, 0, 0, 1, "R6 low stops pump");
    step(0, 0, 0, 0, 1, 0, 0, "R2 lamp clears");
    step(1, 1, 0, 0, 0, 0, 0, "R7 fault no start");
    step(0, 1, 0, 0, 0, 1, 0, "R3 start after fault");

    // R1: reset while pumping
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    push(1'b0, 1'b0, "R1 reset while pumping");
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    empty = 1'b0;
    repeat (4) @(posedge clk);

    wait (sb.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule